// File: doc/BRIEF.md
# Synchronous Burst Data Sequencer

This block is the device-side sequencer for synchronous burst transfers over a 16-bit parallel bus. The host lowers an active-low chip select and keeps the bus clock running. The block counts clock edges from that point. In a read burst it drives a run of words onto the bus, one word per burst slot. In a write burst it captures the words that the host places on the bus. The burst shape is set at run time by one configuration register: enable, single- or double-clock word hold, burst length, first-word latency, trailing wait states, and a write-direction flag.

A second strobe, the exit register, takes the block out of burst write mode. The value written with it is ignored. A small internal counter stands in for the storage array as the read-word source. Each read word carries the number of completed read bursts and the word's index. The block raises a one-cycle completion pulse. It sets an overrun flag when the host keeps clocking past the end of the burst.

Top module: `bseq_top`

## Requirements
- R1: When the enable bit (config bit 0) is 0, a low chip select starts no burst: `bus_oe`, `cap_valid` and `done` stay 0.
- R2: The length field (config bits 3:2) sets the words per burst: code 0 gives 4 words, 1 gives 8, 2 gives 16 and 3 gives 32.
- R3: Number the chip-select-low clock edges from 1. The first word is presented after edge 2+LAT, where LAT is config bits 5:4.
- R4: With the hold bit (config bit 1) at 0, each word occupies one clock. At 1, each word stays for two consecutive clocks. Word i is presented after edge n for n-2-LAT in [0, N·H), with i = (n-2-LAT)/H.
- R5: The wait-state field (config bits 7:6, value W) adds trailing clocks. A complete burst takes exactly 1+LAT+N·H+W chip-select-low edges.
- R6: With the write flag (config bit 8) set, the block never drives the bus. It captures word i on the last clock of its slot and presents it on `cap_data` with `cap_valid` one cycle later. Wait states are counted from the final word, as in R5.
- R7: A pulse on `exit_we` clears the write flag whatever value `reg_wdata` carries. All other configuration fields are left unchanged.
- R8: After reset the configuration is all zeros and `bus_oe`, `done`, `err` and `cap_valid` are 0.
- R9: `bus_oe` is high only while chip select is low and a read word is being presented, never during latency or wait-state clocks.
- R10: `done` pulses for one cycle after the edge at which chip select is sampled high once the full burst length has elapsed. It also pulses when the host clocks one edge past the end.
- R11: `err` is set when chip select is still low on the edge after the full burst length. It stays set until the next burst starts.
- R12: If chip select rises before the burst completes, `bus_oe` drops at once, no `done` is raised, and the next burst starts again from word 0.
- R13: A read word is `{burst_count[10:0], index[4:0]}`. The burst count starts at 0 after reset and advances only on a completed read burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wdata | input | 9 | Register write data |
| cfg_we | input | 1 | Configuration register write strobe |
| exit_we | input | 1 | Exit-burst-write strobe (data ignored) |
| ce_n | input | 1 | Active-low chip select |
| bus_in | input | 16 | Data bus from host (write bursts) |
| bus_out | output | 16 | Data bus toward host (read bursts) |
| bus_oe | output | 1 | Data bus output enable |
| cap_valid | output | 1 | Captured write word valid |
| cap_data | output | 16 | Captured write word |
| done | output | 1 | Burst completion pulse |
| err | output | 1 | Overrun flag |

## Verification
The checker watches several rules on every cycle:
- the output enable is never high while chip select is high or while the write flag is set;
- a disabled block stays idle;
- the completion pulse lasts a single cycle;
- the overrun flag rises only after a low chip-select edge in the active state;
- an exit strobe always clears the write flag;
- an early chip-select rise returns the sequencer to idle without completion;
- the first word lands on edge 2+LAT.

The exact word values and the hold pattern need the bench's scenarios, as do the burst-count progression across completed and aborted bursts, the capture slots in write mode, and the exact edge count for each length, latency and wait-state mix.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int BUS_W     = 16;
    localparam int LEN_W     = 2;
    localparam int LAT_W     = 2;
    localparam int WS_W      = 2;
    localparam int MIN_WORDS = 4;
    localparam int MAX_WORDS = MIN_WORDS << ((1 << LEN_W) - 1);
    localparam int IDX_W     = $clog2(MAX_WORDS);
    localparam int CYC_MAX   = 2 + (1 << LAT_W) + 2 * MAX_WORDS + (1 << WS_W);
    localparam int CYC_W     = $clog2(CYC_MAX);

    typedef struct packed {
        logic             wdir;
        logic [WS_W-1:0]  ws;
        logic [LAT_W-1:0] lat;
        logic [LEN_W-1:0] len;
        logic             hold;
        logic             en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef logic [CYC_W-1:0] cyc_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TAIL = 2'd2
    } st_e;

    // edge index at which the first word appears
    function automatic cyc_t first_cyc(cfg_t c);
        return cyc_t'(2) + cyc_t'(c.lat);
    endfunction

    // clocks occupied by all words (words times hold)
    function automatic cyc_t span_cyc(cfg_t c);
        cyc_t n;
        n = cyc_t'(MIN_WORDS) << c.len;
        return c.hold ? (n << 1) : n;
    endfunction

    // number of low chip-select edges in a complete burst
    function automatic cyc_t end_cyc(cfg_t c);
        return cyc_t'(1) + cyc_t'(c.lat) + span_cyc(c) + cyc_t'(c.ws);
    endfunction

endpackage

// File: rtl/bseq_cfg.sv
module bseq_cfg
    import bseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             exit_we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg_q
);

    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) cfg_d = cfg_t'(wdata);
        if (exit_we) cfg_d.wdir = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

endmodule

// File: rtl/bseq_fsm.sv
module bseq_fsm
    import bseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic en,
    input  cyc_t end_c,
    output st_e  st,
    output cyc_t cyc,
    output logic done,
    output logic err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cyc  <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (!ce_n && en) begin
                        st  <= ST_RUN;
                        cyc <= cyc_t'(1);
                        err <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (ce_n) begin
                        st   <= ST_IDLE;
                        cyc  <= '0;
                        done <= (cyc >= end_c);
                    end else if (cyc >= end_c) begin
                        st   <= ST_TAIL;
                        cyc  <= '0;
                        done <= 1'b1;
                        err  <= 1'b1;
                    end else begin
                        cyc <= cyc + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (ce_n) st <= ST_IDLE;
                end
                default: begin
                    st  <= ST_IDLE;
                    cyc <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/bseq_data.sv
module bseq_data
    import bseq_pkg::*;
#(
    parameter int DW = BUS_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  st_e           st,
    input  cyc_t          cyc,
    input  cyc_t          first_c,
    input  cyc_t          span_c,
    input  logic          hold,
    input  logic          wdir,
    input  logic          done,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic          cap_valid,
    output logic [DW-1:0] cap_data
);

    localparam int NW = DW - IW;

    cyc_t          off;
    logic          in_win;
    logic          cap_slot;
    logic [IW-1:0] idx;
    logic [NW-1:0] bnum;

    assign off    = cyc - first_c;
    assign in_win = (st == ST_RUN) && (cyc >= first_c) && (off < span_c);
    assign idx    = hold ? IW'(off >> 1) : IW'(off);

    assign bus_oe  = in_win && !ce_n && !wdir;
    assign bus_out = bus_oe ? {bnum, idx} : '0;

    // last clock of each word slot
    assign cap_slot = in_win && wdir && !ce_n && (!hold || off[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            bnum      <= '0;
            cap_valid <= 1'b0;
            cap_data  <= '0;
        end else begin
            if (done && !wdir) bnum <= bnum + 1'b1;
            cap_valid <= cap_slot;
            if (cap_slot) cap_data <= bus_in;
        end
    end

endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int DATA_W = BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  reg_wdata,
    input  logic              cfg_we,
    input  logic              exit_we,
    input  logic              ce_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              cap_valid,
    output logic [DATA_W-1:0] cap_data,
    output logic              done,
    output logic              err
);

    cfg_t cfg_q;
    st_e  st;
    cyc_t cyc;
    cyc_t first_c;
    cyc_t span_c;
    cyc_t end_c;

    assign first_c = first_cyc(cfg_q);
    assign span_c  = span_cyc(cfg_q);
    assign end_c   = end_cyc(cfg_q);

    bseq_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (cfg_we),
        .exit_we (exit_we),
        .wdata   (reg_wdata),
        .cfg_q   (cfg_q)
    );

    bseq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .ce_n  (ce_n),
        .en    (cfg_q.en),
        .end_c (end_c),
        .st    (st),
        .cyc   (cyc),
        .done  (done),
        .err   (err)
    );

    bseq_data #(
        .DW (DATA_W),
        .IW (IDX_W)
    ) u_data (
        .clk       (clk),
        .rst       (rst),
        .ce_n      (ce_n),
        .st        (st),
        .cyc       (cyc),
        .first_c   (first_c),
        .span_c    (span_c),
        .hold      (cfg_q.hold),
        .wdir      (cfg_q.wdir),
        .done      (done),
        .bus_in    (bus_in),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .cap_valid (cap_valid),
        .cap_data  (cap_data)
    );

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk
    import bseq_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic ce_n,
    input logic bus_oe,
    input logic done,
    input logic err,
    input logic exit_we,
    input cfg_t cfg,
    input st_e  st,
    input cyc_t cyc
);

    a_r9_oe_needs_ce: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !ce_n);

    a_r6_no_drive_in_write: assert property (@(posedge clk) disable iff (rst)
        cfg.wdir |-> !bus_oe);

    a_r1_idle_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !cfg.en) |=> (st == ST_IDLE));

    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_err_after_overrun: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> ($past(st) == ST_RUN && !$past(ce_n)));

    a_r7_exit_clears_write: assert property (@(posedge clk) disable iff (rst)
        exit_we |=> !cfg.wdir);

    a_r3_first_word_edge: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_oe) && st == ST_RUN) |-> (cyc == first_cyc(cfg)));

    a_r12_abort_to_idle: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && ce_n && cyc < end_cyc(cfg)) |=> (st == ST_IDLE && !done));

endmodule

bind bseq_top bseq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ce_n    (ce_n),
    .bus_oe  (bus_oe),
    .done    (done),
    .err     (err),
    .exit_we (exit_we),
    .cfg     (cfg_q),
    .st      (st),
    .cyc     (cyc)
);

// File: tb/sim_bseq_top.sv
`timescale 1ns/1ps
module sim_bseq_top;
    import bseq_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CFG_W-1:0] reg_wdata = '0;
    logic             cfg_we = 1'b0;
    logic             exit_we = 1'b0;
    logic             ce_n = 1'b1;
    logic [15:0]      bus_in = '0;
    logic [15:0]      bus_out;
    logic             bus_oe;
    logic             cap_valid;
    logic [15:0]      cap_data;
    logic             done;
    logic             err;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [10:0] rd_bursts = '0;
    logic [8:0]  cur = '0;

    // {config[8:0], expected low-edge count[6:0]}
    localparam logic [15:0] VEC [5] = '{
        {9'h001, 7'd5},
        {9'h0A7, 7'd21},
        {9'h0D9, 7'd21},
        {9'h07F, 7'd69},
        {9'h00D, 7'd33}
    };

    always #2 clk = ~clk;

    bseq_top u0 (
        .clk(clk), .rst(rst), .reg_wdata(reg_wdata), .cfg_we(cfg_we),
        .exit_we(exit_we), .ce_n(ce_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .cap_valid(cap_valid), .cap_data(cap_data),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int b_first(input logic [8:0] c);
        return 2 + int'(c[5:4]);
    endfunction
    function automatic int b_hold(input logic [8:0] c);
        return c[1] ? 2 : 1;
    endfunction
    function automatic int b_span(input logic [8:0] c);
        return (4 << c[3:2]) * b_hold(c);
    endfunction
    function automatic int b_end(input logic [8:0] c);
        return 1 + int'(c[5:4]) + b_span(c) + int'(c[7:6]);
    endfunction

    task automatic wr_cfg(input logic [8:0] v);
        @(negedge clk);
        reg_wdata = v;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        cur = v;
    endtask

    task automatic do_exit(input logic [8:0] v);
        @(negedge clk);
        reg_wdata = v;
        exit_we = 1'b1;
        @(negedge clk);
        exit_we = 1'b0;
        cur[8] = 1'b0;
    endtask

    task automatic burst(input int low);
        int f, sp, e, h;
        bit wr, en;
        f  = b_first(cur);
        sp = b_span(cur);
        e  = b_end(cur);
        h  = b_hold(cur);
        wr = cur[8];
        en = cur[0];
        @(negedge clk);
        ce_n = 1'b0;
        for (int k = 1; k <= low; k++) begin
            int d, dp;
            bit win, cv;
            logic [15:0] exp_bus;
            @(negedge clk);
            d   = k - f;
            dp  = k - 1 - f;
            win = en && d >= 0 && d < sp;
            if (!wr) begin
                exp_bus = win ? {rd_bursts, 5'(d / h)} : 16'h0;
                chk(bus_oe == win, "R1 R3 R4 R9 output enable", 32'(bus_oe), 32'(win));
                chk(bus_out == exp_bus, "R2 R4 R13 read word", 32'(bus_out), 32'(exp_bus));
            end else begin
                cv = en && dp >= 0 && dp < sp && (h == 1 || dp % 2 == 1);
                chk(!bus_oe, "R6 no drive in write", 32'(bus_oe), 32'(0));
                chk(cap_valid == cv, "R6 capture valid", 32'(cap_valid), 32'(cv));
                if (cv)
                    chk(cap_data == 16'(32'hC000 + dp / h), "R6 capture data",
                        32'(cap_data), 32'hC000 + 32'(dp / h));
                bus_in = (d >= 0 && d < sp) ? 16'(32'hC000 + d / h) : 16'hFFFF;
            end
            chk(done == (en && k == e + 1), "R10 done during burst", 32'(done), 32'(en && k == e + 1));
            chk(err == (en && k > e), "R11 err during burst", 32'(err), 32'(en && k > e));
        end
        ce_n = 1'b1;
        #1;
        chk(!bus_oe, "R12 R9 enable drops with chip select", 32'(bus_oe), 32'(0));
        @(negedge clk);
        chk(done == (en && low == e), "R5 R10 R12 done at end", 32'(done), 32'(en && low == e));
        chk(err == (en && low > e), "R11 err after burst", 32'(err), 32'(en && low > e));
        if (en && !wr && low >= e) rd_bursts++;
        @(negedge clk);
        chk(!done, "R10 done is a pulse", 32'(done), 32'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_oe && !done && !err && !cap_valid, "R8 reset outputs",
            {28'h0, bus_oe, done, err, cap_valid}, 32'h0);
        // R8 R1: reset config leaves bursts disabled
        burst(6);

        for (int i = 0; i < 5; i++) begin
            wr_cfg(VEC[i][15:7]);
            chk(b_end(cur) == int'(VEC[i][6:0]), "R5 table length", 32'(b_end(cur)), 32'(VEC[i][6:0]));
            burst(int'(VEC[i][6:0]));
        end

        // R11: one edge beyond the end
        wr_cfg(9'h001);
        burst(6);

        // R12: early chip-select rise, then a full burst
        wr_cfg(9'h0A7);
        burst(9);
        burst(21);

        // R6: write bursts, double then single hold
        wr_cfg(9'h1A7);
        burst(21);
        wr_cfg(9'h1D9);
        burst(21);

        // R7: exit with a zero value keeps enable and other fields
        do_exit(9'h000);
        chk(b_end(cur) == 21, "R7 fields kept", 32'(b_end(cur)), 32'd21);
        burst(21);

        // R1: enable clear
        wr_cfg(9'h0A6);
        burst(10);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule